// File: doc/BRIEF.md
# Operand-Reducing Radix-4 Booth Multiplier

This block multiplies two signed 16-bit operands and returns the full 32-bit signed product. Before the operands enter the multiplier array, each one can be shortened on its own, to lower switching activity in the array. An operand can be left as it is, truncated by clearing its N low bits (its scale stays the same), or shifted right arithmetically by N places with sign fill. The caller chooses the count N for each operand separately.

The array uses radix-4 modified Booth recoding. One operand is recoded into eight signed digits, and the other operand feeds the partial products directly. Power in the array depends more on the non-recoded operand, so a swap input picks which of the two reduced operands goes to the recoded side. The swap changes which port each operand reaches. It does not change the product. The block does no rescaling after a shift. That is left to the caller.

Inputs are captured on a valid strobe. The product comes out two cycles later, flagged by an output valid.

Top module: `opred_mul`

## Requirements
- R1: `prod_o` is the exact 32-bit two's-complement product of the two reduced 16-bit two's-complement operands.
- R2: Mode code 2'b01 (truncate) with count N clears the N least significant bits of that operand and leaves its upper 16-N bits in place.
- R3: Mode code 2'b10 (shift) with count N shifts that operand right arithmetically by N places, filling the top bits with its sign bit. The product is not rescaled afterwards.
- R4: Mode code 2'b00 (pass) and the spare code 2'b11 both leave the operand unchanged.
- R5: A count of 0 leaves the operand unchanged in every mode. Counts from 0 to 15 are accepted, and 8 is a normal setting.
- R6: The mode and count of operand A affect only A, and those of operand B affect only B.
- R7: With `swap_i`=0 the reduced A is Booth-recoded and B is not. With `swap_i`=1 the roles are exchanged. The product is the same either way.
- R8: An operand of 0x8000 gives the correct product on either the recoded port or the non-recoded port.
- R9: When `valid_i` is high at rising edge k, `valid_o` is high, with that input's product, after rising edge k+1. Each accepted input gives exactly one output cycle, and inputs may arrive back to back.
- R10: While `valid_o` is low, `prod_o` keeps the last product.
- R11: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| a_i | input | 16 | Operand A, signed |
| b_i | input | 16 | Operand B, signed |
| a_mode_i | input | 2 | Reduction mode for A |
| a_cnt_i | input | 4 | Reduction count N for A |
| b_mode_i | input | 2 | Reduction mode for B |
| b_cnt_i | input | 4 | Reduction count N for B |
| swap_i | input | 1 | Selects which operand is recoded (0: A, 1: B) |
| valid_o | output | 1 | Product valid |
| prod_o | output | 32 | Signed product |

## Verification
A bad partial product for a single Booth digit shows up as a wrong `prod_o` in the cycle its `valid_o` rises, two edges after the input is taken. The error appears only for multipliers whose digit at that position is non-zero, so the sweep uses edge values, alternating patterns and random values under every mode, count and swap setting. A wrong reduction mask or wrong shift fill shows up as soon as a negative operand is reduced. A broken hold or valid pipeline shows up in the idle cycles between bursts, as a product that changes or a valid that appears on the wrong cycle.

// File: rtl/opred_pkg.sv
package opred_pkg;
  typedef enum logic [1:0] {
    RED_PASS  = 2'b00,
    RED_TRUNC = 2'b01,
    RED_SHIFT = 2'b10,
    RED_SPARE = 2'b11
  } red_mode_e;
endpackage

// File: rtl/opred_reduce.sv
module opred_reduce #(
  parameter int unsigned W    = 16,
  parameter int unsigned CW   = $clog2(W)
) (
  input  logic signed [W-1:0]  op_i,
  input  logic        [1:0]    mode_i,
  input  logic        [CW-1:0] cnt_i,
  output logic signed [W-1:0]  op_o
);
  import opred_pkg::*;

  logic [W-1:0] keep_mask;
  assign keep_mask = {W{1'b1}} << cnt_i;

  always_comb begin
    unique case (red_mode_e'(mode_i))
      RED_TRUNC: op_o = op_i & keep_mask;
      RED_SHIFT: op_o = op_i >>> cnt_i;
      default:   op_o = op_i;
    endcase
  end
endmodule

// File: rtl/opred_booth_pp.sv
// One radix-4 Booth partial product, already weighted by 4**IDX.
module opred_booth_pp #(
  parameter int unsigned W   = 16,
  parameter int unsigned PW  = 2*W,
  parameter int unsigned IDX = 0
) (
  input  logic signed [W-1:0]  mcand_i,
  input  logic        [2:0]    trip_i,
  output logic signed [PW-1:0] pp_o
);
  localparam int unsigned XW = W + 2;

  logic signed [XW-1:0] ext, mag;
  assign ext = mcand_i;

  always_comb begin
    unique case (trip_i)
      3'b001, 3'b010: mag = ext;
      3'b011:         mag = ext <<< 1;
      3'b100:         mag = -(ext <<< 1);
      3'b101, 3'b110: mag = -ext;
      default:        mag = '0;
    endcase
  end

  logic signed [PW-1:0] mag_sx;
  assign mag_sx = mag;
  assign pp_o   = mag_sx <<< (2*IDX);
endmodule

// File: rtl/opred_booth_core.sv
// W must be even.
module opred_booth_core #(
  parameter int unsigned W  = 16,
  parameter int unsigned PW = 2*W
) (
  input  logic signed [W-1:0]  rec_i,
  input  logic signed [W-1:0]  nrec_i,
  output logic signed [PW-1:0] prod_o
);
  localparam int unsigned NPP = W / 2;

  logic signed [PW-1:0] pp [NPP];

  for (genvar g = 0; g < NPP; g++) begin : g_pp
    logic [2:0] trip;
    if (g == 0) begin : g_lsb
      assign trip = {rec_i[1:0], 1'b0};
    end else begin : g_mid
      assign trip = rec_i[2*g+1 : 2*g-1];
    end
    opred_booth_pp #(.W(W), .PW(PW), .IDX(g)) u_pp (
      .mcand_i (nrec_i),
      .trip_i  (trip),
      .pp_o    (pp[g])
    );
  end

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < NPP; k++) prod_o = prod_o + pp[k];
  end
endmodule

// File: rtl/opred_mul.sv
module opred_mul #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned CNT_W  = $clog2(OP_W),
  parameter int unsigned PROD_W = 2*OP_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [OP_W-1:0]   a_i,
  input  logic signed [OP_W-1:0]   b_i,
  input  logic        [1:0]        a_mode_i,
  input  logic        [CNT_W-1:0]  a_cnt_i,
  input  logic        [1:0]        b_mode_i,
  input  logic        [CNT_W-1:0]  b_cnt_i,
  input  logic                     swap_i,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [OP_W-1:0] a_red, b_red, rec_d, nrec_d, rec_q, nrec_q;
  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic s1_vld, s2_vld;

  opred_reduce #(.W(OP_W), .CW(CNT_W)) u_red_a (
    .op_i(a_i), .mode_i(a_mode_i), .cnt_i(a_cnt_i), .op_o(a_red)
  );
  opred_reduce #(.W(OP_W), .CW(CNT_W)) u_red_b (
    .op_i(b_i), .mode_i(b_mode_i), .cnt_i(b_cnt_i), .op_o(b_red)
  );

  assign rec_d  = swap_i ? b_red : a_red;
  assign nrec_d = swap_i ? a_red : b_red;

  // operand registers only load on valid to keep the array quiet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      rec_q  <= '0;
      nrec_q <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        rec_q  <= rec_d;
        nrec_q <= nrec_d;
      end
    end
  end

  opred_booth_core #(.W(OP_W), .PW(PROD_W)) u_core (
    .rec_i(rec_q), .nrec_i(nrec_q), .prod_o(prod_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      prod_q <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) prod_q <= prod_d;
    end
  end

  assign valid_o = s2_vld;
  assign prod_o  = prod_q;
endmodule

// File: rtl/opred_mul_chk.sv
module opred_mul_chk #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned CNT_W  = $clog2(OP_W),
  parameter int unsigned PROD_W = 2*OP_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [OP_W-1:0]   a_i,
  input logic signed [OP_W-1:0]   b_i,
  input logic        [1:0]        a_mode_i,
  input logic        [CNT_W-1:0]  a_cnt_i,
  input logic        [1:0]        b_mode_i,
  input logic        [CNT_W-1:0]  b_cnt_i,
  input logic                     swap_i,
  input logic                     valid_o,
  input logic signed [PROD_W-1:0] prod_o
);
  function automatic logic signed [OP_W-1:0] red_f(logic signed [OP_W-1:0] v,
                                                    logic [1:0] m, logic [CNT_W-1:0] n);
    logic signed [OP_W-1:0] s;
    s = v >>> n;
    if (m == 2'b01)      red_f = s <<< n;
    else if (m == 2'b10) red_f = s;
    else                 red_f = v;
  endfunction

  logic signed [PROD_W-1:0] ea, eb, ref1, ref2;
  logic v1;
  assign ea = red_f(a_i, a_mode_i, a_cnt_i);
  assign eb = red_f(b_i, b_mode_i, b_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; ref1 <= '0; ref2 <= '0;
    end else begin
      v1 <= valid_i;
      if (valid_i) ref1 <= ea * eb;
      if (v1)      ref2 <= ref1;
    end
  end

  // R1 R8: product equals behavioural product of reduced operands, any swap
  p_prod_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> prod_o == ref2);
  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(prod_o));
  p_reset_r11: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && prod_o == '0));
endmodule

bind opred_mul opred_mul_chk #(.OP_W(OP_W), .CNT_W(CNT_W), .PROD_W(PROD_W)) u_chk (.*);

// File: tb/opred_mul_tb.sv
`timescale 1ns/1ps
module opred_mul_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, swap_i = 1'b0;
  logic signed [15:0] a_i = '0, b_i = '0;
  logic [1:0] a_mode_i = '0, b_mode_i = '0;
  logic [3:0] a_cnt_i = '0, b_cnt_i = '0;
  logic valid_o;
  logic signed [31:0] prod_o;

  opred_mul u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int errs = 0, chks = 0, cyc = 0;
  bit done = 1'b0;
  longint q_exp[$];
  int q_cyc[$];
  string q_tag[$];
  longint last_prod = 0;

  // floor(v / 2**n) by plain integer arithmetic
  function automatic longint fdiv(longint v, int n);
    longint p = longint'(1) << n;
    if (v >= 0) return v / p;
    return -((-v + p - 1) / p);
  endfunction

  function automatic longint red(longint v, int m, int n);
    if (m == 1) return fdiv(v, n) * (longint'(1) << n);
    if (m == 2) return fdiv(v, n);
    return v;
  endfunction

  function automatic string pick_tag(longint a, longint b, int am, int an,
                                     int bm, int bn, bit sw);
    if (a == -32768 || b == -32768) return "R8";
    if (am == 3 || bm == 3) return "R4";
    if ((am != 0 && an == 0) || (bm != 0 && bn == 0)) return "R5";
    if (sw) return "R7";
    if (am != 0 && bm != 0 && (am != bm || an != bn)) return "R6";
    if (am == 2 || bm == 2) return "R3";
    if (am == 1 || bm == 1) return "R2";
    return "R1";
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // observe at negedge, then drive the next inputs
  task automatic step(bit v, longint a, longint b, int am, int an, int bm, int bn, bit sw);
    @(negedge clk_i);
    cyc++;
    if (valid_o) begin
      if (q_exp.size() == 0) chk(1'b0, "R9", 1, 0);
      else begin
        longint e = q_exp.pop_front();
        int c = q_cyc.pop_front();
        string t = q_tag.pop_front();
        chk(cyc - c == 2, "R9", cyc - c, 2);
        chk(longint'(prod_o) == e, t, prod_o, e);
        last_prod = prod_o;
      end
    end else begin
      chk(longint'(prod_o) == last_prod, "R10", prod_o, last_prod);
    end
    valid_i = v; a_i = 16'(a); b_i = 16'(b);
    a_mode_i = 2'(am); a_cnt_i = 4'(an); b_mode_i = 2'(bm); b_cnt_i = 4'(bn);
    swap_i = sw;
    if (v) begin
      q_exp.push_back(red(a, am, an) * red(b, bm, bn));
      q_cyc.push_back(cyc);
      q_tag.push_back(pick_tag(a, b, am, an, bm, bn, sw));
    end
  endtask

  longint pats[8] = '{0, 1, -1, 32767, -32768, 4660, -21846, 23130};
  int cnts[5] = '{0, 1, 7, 8, 15};

  initial begin
    int nvec = 0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0 && prod_o == 0, "R11", prod_o, 0);
    rst_ni = 1'b1;
    for (int am = 0; am < 4; am++)
      for (int bm = 0; bm < 4; bm++)
        for (int ai = 0; ai < 5; ai++)
          for (int bi = 0; bi < 5; bi++)
            for (int sw = 0; sw < 2; sw++) begin
              for (int p = 0; p < 10; p++) begin
                longint a = (p < 8) ? pats[p] : longint'($signed(16'($urandom)));
                longint b = (p < 8) ? pats[(p*3+1)%8] : longint'($signed(16'($urandom)));
                step(1'b1, a, b, am, cnts[ai], bm, cnts[bi], sw[0]);
                nvec++;
                if (nvec % 13 == 0) step(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
              end
            end
    // both swap settings on the most negative operand pair
    step(1'b1, -32768, -32768, 0, 0, 0, 0, 1'b0);
    step(1'b1, -32768, -32768, 0, 0, 0, 0, 1'b1);
    repeat (4) step(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk(q_exp.size() == 0, "R9", q_exp.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule